// File: doc/BRIEF.md
# SPI FIFO Status and Interrupt Unit

This block holds the data buffers and event logic that sit between a register bus and an SPI serial shifter. A transmit queue is filled by the bus and drained by the shifter. A receive queue is filled by the shifter and drained by the bus. Both queues report their fill levels. A small set of configuration registers holds the thresholds, the interrupt mask, the request enables and the request levels. From these the block derives a status word, raw and masked interrupt vectors, one combined interrupt line and two DMA request lines.

Software learns the queue depth by writing rising values to a threshold register and watching where read-back stops following the write. It drains the receive queue by popping while the receive level is nonzero. Error events are held until software clears them through a write-only clear selector. A bus pop from an empty receive queue returns zero.

Top module: `spi_fifo_event_unit`

## Requirements
- R1: After synchronous reset both levels are 0, status is 5'b01100, the raw interrupt vector is 5'b10001 (both thresholds reset to 0), the mask and request enables are 0, and irq and both request lines are low.
- R2: Words pushed by the bus leave the transmit queue at eng_tx_data in push order, and tx_level counts the entries, up to DEPTH.
- R3: Status bit positions: bit0 is engine busy, bit1 transmit full, bit2 transmit empty, bit3 receive empty, bit4 receive full.
- R4: A bus push while the transmit queue is full is dropped, the level stays DEPTH, and raw bit1 (transmit overflow) latches. Fullness is judged before any same-cycle engine pop.
- R5: A bus pop while the receive queue is empty loads 0 into bus_rx_data and latches raw bit2 (receive underflow).
- R6: An engine push while the receive queue is full is dropped and latches raw bit3 (receive overflow).
- R7: Raw bit0 is high while tx_level <= transmit threshold. Raw bit4 is high while rx_level >= receive threshold.
- R8: A write to selector 3 clears latched events: data bit0 clears bits 1, 2 and 3; bit1 clears receive underflow; bit2 clears receive overflow; bit3 clears transmit overflow. An event in the same cycle as its clear stays set.
- R9: Selectors 0, 1, 5 and 6 (transmit threshold, receive threshold, transmit request level, receive request level) take a write only if the value is below DEPTH, and otherwise keep the old value. cfg_rdata shows the register chosen by cfg_sel one cycle later. Selector 2 is the mask, 4 the request enables, and 3 and 7 read 0.
- R10: masked_int equals raw_int AND mask, and irq is the OR of masked_int.
- R11: With enable bit1 set, tx_dma_req is high while tx_level <= transmit request level. With enable bit0 set, rx_dma_req is high while rx_level > receive request level. Each line is low while its enable is clear.
- R12: A bus pop from a non-empty receive queue loads the oldest word into bus_rx_data on the next edge, and rx_level drops by one.
- R13: Status bit0 follows eng_busy one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_tx_push | input | 1 | Bus writes a word into the transmit queue |
| bus_tx_data | input | DW | Word to push |
| bus_rx_pop | input | 1 | Bus reads a word from the receive queue |
| bus_rx_data | output | DW | Last word popped (0 after an empty pop) |
| eng_tx_pop | input | 1 | Shifter takes the head of the transmit queue |
| eng_tx_data | output | DW | Head of the transmit queue |
| eng_rx_push | input | 1 | Shifter stores a received word |
| eng_rx_data | input | DW | Received word |
| eng_busy | input | 1 | Shifter is active |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 3 | Configuration register selector |
| cfg_wdata | input | CW | Configuration write data |
| cfg_rdata | output | CW | Registered read-back of the selected register |
| tx_level | output | LW | Transmit queue entries |
| rx_level | output | LW | Receive queue entries |
| status | output | 5 | Status word |
| raw_int | output | 5 | Raw interrupt vector |
| masked_int | output | 5 | Masked interrupt vector |
| irq | output | 1 | Combined interrupt |
| tx_dma_req | output | 1 | Transmit DMA request |
| rx_dma_req | output | 1 | Receive DMA request |

## Verification
Two functions can land on the same edge: a clear of a latched error and a fresh instance of that error. The bench provokes this by writing the underflow clear in the same cycle as a pop from an empty receive queue. It then judges that raw bit2 is still set. A later clear with no event must drop only the bit it names. A second collision pairs a full-queue bus push with an engine pop in one cycle, and the push must still be dropped and flagged.

// File: rtl/sfq_pkg.sv
package sfq_pkg;
  // status word bit positions
  localparam int ST_BUSY = 0;
  localparam int ST_TXF  = 1;
  localparam int ST_TXE  = 2;
  localparam int ST_RXE  = 3;
  localparam int ST_RXF  = 4;
  // interrupt vector bit positions
  localparam int IR_TXTH = 0;
  localparam int IR_TXOV = 1;
  localparam int IR_RXUN = 2;
  localparam int IR_RXOV = 3;
  localparam int IR_RXTH = 4;
  localparam int NIRQ    = 5;
  // clear selector data bits
  localparam int CL_ALL  = 0;
  localparam int CL_RXUN = 1;
  localparam int CL_RXOV = 2;
  localparam int CL_TXOV = 3;

  typedef enum logic [2:0] {
    SEL_TXTH = 3'd0,
    SEL_RXTH = 3'd1,
    SEL_MASK = 3'd2,
    SEL_CLR  = 3'd3,
    SEL_DMAC = 3'd4,
    SEL_TXDL = 3'd5,
    SEL_RXDL = 3'd6,
    SEL_NONE = 3'd7
  } cfg_sel_e;
endpackage

// File: rtl/sfq_fifo.sv
module sfq_fifo #(
  parameter int DW    = 16,
  parameter int DEPTH = 8,
  parameter int LW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic [DW-1:0] wdata,
  input  logic          pop,
  output logic [DW-1:0] rdata,
  output logic [LW-1:0] level,
  output logic          full,
  output logic          empty
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [LW-1:0] FULL_CNT = LW'(DEPTH);

  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr, wr_nxt, rd_nxt;
  logic          do_push, do_pop;

  assign full    = (level == FULL_CNT);
  assign empty   = (level == '0);
  assign do_push = push & ~full;
  assign do_pop  = pop & ~empty;
  assign rdata   = mem[rd_ptr];

  generate
    if ((DEPTH & (DEPTH - 1)) == 0) begin : g_pow2
      assign wr_nxt = wr_ptr + 1'b1;
      assign rd_nxt = rd_ptr + 1'b1;
    end else begin : g_wrap
      assign wr_nxt = (wr_ptr == PW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      assign rd_nxt = (rd_ptr == PW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else begin
      if (do_push) wr_ptr <= wr_nxt;
      if (do_pop)  rd_ptr <= rd_nxt;
      case ({do_push, do_pop})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end

  a_r2_level_bound: assert property (@(posedge clk) disable iff (rst)
    level <= FULL_CNT);
  a_r4_full_drop: assert property (@(posedge clk) disable iff (rst)
    (push && full && !pop) |=> (level == FULL_CNT));
  a_r5_empty_pop: assert property (@(posedge clk) disable iff (rst)
    (pop && empty && !push) |=> (level == '0));
endmodule

// File: rtl/sfq_cfg.sv
module sfq_cfg
  import sfq_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int CW    = 8,
  parameter int LW    = $clog2(DEPTH + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            we,
  input  logic [2:0]      sel,
  input  logic [CW-1:0]   wdata,
  output logic [LW-1:0]   tx_thr,
  output logic [LW-1:0]   rx_thr,
  output logic [NIRQ-1:0] mask,
  output logic [1:0]      dma_en,
  output logic [LW-1:0]   tx_dl,
  output logic [LW-1:0]   rx_dl,
  output logic [3:0]      clr,
  output logic [CW-1:0]   rdata
);
  logic in_range;
  logic [CW-1:0] rd_mux;

  assign in_range = (wdata < CW'(DEPTH));
  assign clr = (we && sel == SEL_CLR) ? wdata[3:0] : 4'b0000;

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_thr <= '0;
      rx_thr <= '0;
      mask   <= '0;
      dma_en <= '0;
      tx_dl  <= '0;
      rx_dl  <= '0;
    end else if (we) begin
      case (cfg_sel_e'(sel))
        SEL_TXTH: if (in_range) tx_thr <= wdata[LW-1:0];
        SEL_RXTH: if (in_range) rx_thr <= wdata[LW-1:0];
        SEL_MASK: mask   <= wdata[NIRQ-1:0];
        SEL_DMAC: dma_en <= wdata[1:0];
        SEL_TXDL: if (in_range) tx_dl <= wdata[LW-1:0];
        SEL_RXDL: if (in_range) rx_dl <= wdata[LW-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    rd_mux = '0;
    case (cfg_sel_e'(sel))
      SEL_TXTH: rd_mux = CW'(tx_thr);
      SEL_RXTH: rd_mux = CW'(rx_thr);
      SEL_MASK: rd_mux = CW'(mask);
      SEL_DMAC: rd_mux = CW'(dma_en);
      SEL_TXDL: rd_mux = CW'(tx_dl);
      SEL_RXDL: rd_mux = CW'(rx_dl);
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd_mux;
  end

  a_r9_thr_range: assert property (@(posedge clk) disable iff (rst)
    (tx_thr < LW'(DEPTH)) && (rx_thr < LW'(DEPTH)));
  a_r9_reject_big: assert property (@(posedge clk) disable iff (rst)
    (we && sel == SEL_TXTH && !in_range) |=> $stable(tx_thr));
endmodule

// File: rtl/sfq_irq.sv
module sfq_irq
  import sfq_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            tx_ovf_evt,
  input  logic            rx_unf_evt,
  input  logic            rx_ovf_evt,
  input  logic            tx_below,
  input  logic            rx_above,
  input  logic [3:0]      clr,
  input  logic [NIRQ-1:0] mask,
  output logic [NIRQ-1:0] raw,
  output logic [NIRQ-1:0] masked,
  output logic            irq
);
  logic tx_ovf_q, rx_unf_q, rx_ovf_q;
  logic kill_txov, kill_rxun, kill_rxov;

  assign kill_txov = clr[CL_ALL] | clr[CL_TXOV];
  assign kill_rxun = clr[CL_ALL] | clr[CL_RXUN];
  assign kill_rxov = clr[CL_ALL] | clr[CL_RXOV];

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_ovf_q <= 1'b0;
      rx_unf_q <= 1'b0;
      rx_ovf_q <= 1'b0;
    end else begin
      // a fresh event outranks a clear on the same edge
      tx_ovf_q <= (tx_ovf_q & ~kill_txov) | tx_ovf_evt;
      rx_unf_q <= (rx_unf_q & ~kill_rxun) | rx_unf_evt;
      rx_ovf_q <= (rx_ovf_q & ~kill_rxov) | rx_ovf_evt;
    end
  end

  always_comb begin
    raw          = '0;
    raw[IR_TXTH] = tx_below;
    raw[IR_TXOV] = tx_ovf_q;
    raw[IR_RXUN] = rx_unf_q;
    raw[IR_RXOV] = rx_ovf_q;
    raw[IR_RXTH] = rx_above;
  end

  assign masked = raw & mask;
  assign irq    = |masked;

  a_r8_event_wins: assert property (@(posedge clk) disable iff (rst)
    rx_unf_evt |=> raw[IR_RXUN]);
  a_r8_sticky_hold: assert property (@(posedge clk) disable iff (rst)
    (raw[IR_TXOV] && !clr[CL_ALL] && !clr[CL_TXOV]) |=> raw[IR_TXOV]);
  a_r6_ovf_latch: assert property (@(posedge clk) disable iff (rst)
    rx_ovf_evt |=> raw[IR_RXOV]);
endmodule

// File: rtl/sfq_dma.sv
module sfq_dma #(
  parameter int LW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [1:0]    dma_en,
  input  logic [LW-1:0] tx_level,
  input  logic [LW-1:0] rx_level,
  input  logic [LW-1:0] tx_dl,
  input  logic [LW-1:0] rx_dl,
  output logic          tx_req,
  output logic          rx_req
);
  assign tx_req = dma_en[1] & (tx_level <= tx_dl);
  assign rx_req = dma_en[0] & (rx_level > rx_dl);

  a_r11_rx_req_data: assert property (@(posedge clk) disable iff (rst)
    rx_req |-> (rx_level != '0));
endmodule

// File: rtl/spi_fifo_event_unit.sv
module spi_fifo_event_unit
  import sfq_pkg::*;
#(
  parameter int DW    = 16,
  parameter int DEPTH = 8,
  parameter int CW    = 8,
  parameter int LW    = $clog2(DEPTH + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            bus_tx_push,
  input  logic [DW-1:0]   bus_tx_data,
  input  logic            bus_rx_pop,
  output logic [DW-1:0]   bus_rx_data,
  input  logic            eng_tx_pop,
  output logic [DW-1:0]   eng_tx_data,
  input  logic            eng_rx_push,
  input  logic [DW-1:0]   eng_rx_data,
  input  logic            eng_busy,
  input  logic            cfg_we,
  input  logic [2:0]      cfg_sel,
  input  logic [CW-1:0]   cfg_wdata,
  output logic [CW-1:0]   cfg_rdata,
  output logic [LW-1:0]   tx_level,
  output logic [LW-1:0]   rx_level,
  output logic [4:0]      status,
  output logic [4:0]      raw_int,
  output logic [4:0]      masked_int,
  output logic            irq,
  output logic            tx_dma_req,
  output logic            rx_dma_req
);
  logic          tx_full, tx_empty, rx_full, rx_empty;
  logic [DW-1:0] rx_head;
  logic          busy_q;
  logic [LW-1:0] tx_thr, rx_thr, tx_dl, rx_dl;
  logic [NIRQ-1:0] mask;
  logic [1:0]    dma_en;
  logic [3:0]    clr;

  sfq_fifo #(.DW(DW), .DEPTH(DEPTH), .LW(LW)) u_txq (
    .clk(clk), .rst(rst),
    .push(bus_tx_push), .wdata(bus_tx_data),
    .pop(eng_tx_pop), .rdata(eng_tx_data),
    .level(tx_level), .full(tx_full), .empty(tx_empty)
  );

  sfq_fifo #(.DW(DW), .DEPTH(DEPTH), .LW(LW)) u_rxq (
    .clk(clk), .rst(rst),
    .push(eng_rx_push), .wdata(eng_rx_data),
    .pop(bus_rx_pop), .rdata(rx_head),
    .level(rx_level), .full(rx_full), .empty(rx_empty)
  );

  sfq_cfg #(.DEPTH(DEPTH), .CW(CW), .LW(LW)) u_cfg (
    .clk(clk), .rst(rst),
    .we(cfg_we), .sel(cfg_sel), .wdata(cfg_wdata),
    .tx_thr(tx_thr), .rx_thr(rx_thr), .mask(mask), .dma_en(dma_en),
    .tx_dl(tx_dl), .rx_dl(rx_dl), .clr(clr), .rdata(cfg_rdata)
  );

  sfq_irq u_irq (
    .clk(clk), .rst(rst),
    .tx_ovf_evt(bus_tx_push & tx_full),
    .rx_unf_evt(bus_rx_pop & rx_empty),
    .rx_ovf_evt(eng_rx_push & rx_full),
    .tx_below(tx_level <= tx_thr),
    .rx_above(rx_level >= rx_thr),
    .clr(clr), .mask(mask),
    .raw(raw_int), .masked(masked_int), .irq(irq)
  );

  sfq_dma #(.LW(LW)) u_dma (
    .clk(clk), .rst(rst), .dma_en(dma_en),
    .tx_level(tx_level), .rx_level(rx_level),
    .tx_dl(tx_dl), .rx_dl(rx_dl),
    .tx_req(tx_dma_req), .rx_req(rx_dma_req)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q      <= 1'b0;
      bus_rx_data <= '0;
    end else begin
      busy_q <= eng_busy;
      if (bus_rx_pop) bus_rx_data <= rx_empty ? '0 : rx_head;
    end
  end

  always_comb begin
    status         = '0;
    status[ST_BUSY] = busy_q;
    status[ST_TXF]  = tx_full;
    status[ST_TXE]  = tx_empty;
    status[ST_RXE]  = rx_empty;
    status[ST_RXF]  = rx_full;
  end

  a_r5_zero_on_empty: assert property (@(posedge clk) disable iff (rst)
    (bus_rx_pop && rx_empty) |=> (bus_rx_data == '0));
  a_r13_busy_follow: assert property (@(posedge clk) disable iff (rst)
    eng_busy |=> status[ST_BUSY]);
  a_r3_flags_excl: assert property (@(posedge clk) disable iff (rst)
    !(status[ST_TXF] && status[ST_TXE]) && !(status[ST_RXF] && status[ST_RXE]));
endmodule

// File: tb/sim_spi_fifo_event_unit.sv
module sim_spi_fifo_event_unit;
  localparam int DW = 16, DEPTH = 8, CW = 8, LW = 4;

  logic clk = 0, rst = 1;
  logic bus_tx_push = 0, bus_rx_pop = 0, eng_tx_pop = 0, eng_rx_push = 0, eng_busy = 0;
  logic [DW-1:0] bus_tx_data = '0, eng_rx_data = '0;
  logic cfg_we = 0;
  logic [2:0] cfg_sel = 3'd7;
  logic [CW-1:0] cfg_wdata = '0;
  logic [DW-1:0] bus_rx_data, eng_tx_data;
  logic [CW-1:0] cfg_rdata;
  logic [LW-1:0] tx_level, rx_level;
  logic [4:0] status, raw_int, masked_int;
  logic irq, tx_dma_req, rx_dma_req;

  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  spi_fifo_event_unit #(.DW(DW), .DEPTH(DEPTH), .CW(CW), .LW(LW)) u0 (.*);

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic cfg_write(input int sel, input int val);
    cfg_we = 1; cfg_sel = 3'(sel); cfg_wdata = CW'(val);
    tick();
    cfg_we = 0; cfg_sel = 3'd7;
  endtask

  task automatic cfg_read(input int sel, output int val);
    cfg_sel = 3'(sel);
    tick();
    val = int'(cfg_rdata);
    cfg_sel = 3'd7;
  endtask

  task automatic bus_push(input int d);
    bus_tx_push = 1; bus_tx_data = DW'(d); tick(); bus_tx_push = 0;
  endtask

  task automatic eng_push(input int d);
    eng_rx_push = 1; eng_rx_data = DW'(d); tick(); eng_rx_push = 0;
  endtask

  task automatic bus_pop();
    bus_rx_pop = 1; tick(); bus_rx_pop = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual 0 expected 1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int v, prev, accepted, lvl;
    repeat (3) tick();
    rst = 0;
    tick();
    // R1 reset state
    chk("R1 tx_level", tx_level, 0);
    chk("R1 rx_level", rx_level, 0);
    chk("R1 status", status, 5'b01100);
    chk("R1 raw", raw_int, 5'b10001);
    chk("R1 irq", irq, 0);
    chk("R1 dma", {tx_dma_req, rx_dma_req}, 0);

    // R9 threshold write acceptance and depth discovery
    prev = 0; accepted = 0;
    for (int w = 0; w < 16; w++) begin
      cfg_write(0, w);
      cfg_read(0, v);
      if (w < DEPTH) prev = w;
      if (v == w) accepted++;
      chk("R9 tx threshold readback", v, prev);
    end
    chk("R9 depth discovery", accepted, DEPTH);
    cfg_write(1, 12);
    cfg_read(1, v);
    chk("R9 rx threshold rejects big", v, 0);
    cfg_write(1, 5);
    cfg_read(1, v);
    chk("R9 rx threshold accept", v, 5);
    cfg_write(0, 3);
    cfg_read(3, v);
    chk("R9 clear selector reads zero", v, 0);

    // R2 R3 R7 transmit fill
    for (int i = 0; i < DEPTH; i++) begin
      bus_push(16'hA000 + i);
      chk("R2 tx_level fill", tx_level, i + 1);
      chk("R3 tx full bit", status[1], (i + 1 == DEPTH));
      chk("R3 tx empty bit", status[2], 0);
      chk("R7 tx threshold bit", raw_int[0], (i + 1 <= 3));
    end
    // R4 overflow with a same-cycle engine pop: push still dropped
    chk("R4 no overflow yet", raw_int[1], 0);
    bus_tx_push = 1; bus_tx_data = 16'hBEEF; eng_tx_pop = 1;
    tick();
    bus_tx_push = 0; eng_tx_pop = 0;
    chk("R4 overflow latched", raw_int[1], 1);
    chk("R4 level after drop and pop", tx_level, DEPTH - 1);
    // R2 drain order, the dropped word never appears
    for (int i = 1; i < DEPTH; i++) begin
      chk("R2 head order", eng_tx_data, 16'hA000 + i);
      eng_tx_pop = 1; tick(); eng_tx_pop = 0;
      chk("R2 tx_level drain", tx_level, DEPTH - 1 - i);
    end
    chk("R3 tx empty", status[2], 1);
    eng_tx_pop = 1; tick(); eng_tx_pop = 0;
    chk("R2 pop empty tx ignored", tx_level, 0);

    // R8 selective clear of transmit overflow
    cfg_write(3, 4'b1000);
    chk("R8 tx overflow cleared", raw_int[1], 0);

    // R6 R7 R12 receive fill and drain
    for (int i = 0; i < DEPTH; i++) begin
      eng_push(16'h5000 + 3 * i);
      chk("R12 rx_level fill", rx_level, i + 1);
      chk("R7 rx threshold bit", raw_int[4], (i + 1 >= 5));
      chk("R3 rx full bit", status[4], (i + 1 == DEPTH));
      chk("R3 rx empty bit", status[3], 0);
    end
    eng_push(16'h7777);
    chk("R6 rx overflow latched", raw_int[3], 1);
    chk("R6 level held", rx_level, DEPTH);
    for (int i = 0; i < DEPTH; i++) begin
      bus_pop();
      chk("R12 popped word", bus_rx_data, 16'h5000 + 3 * i);
      chk("R12 rx_level drain", rx_level, DEPTH - 1 - i);
    end
    // R5 underflow
    chk("R5 no underflow yet", raw_int[2], 0);
    bus_pop();
    chk("R5 empty pop data", bus_rx_data, 0);
    chk("R5 underflow latched", raw_int[2], 1);

    // R8 collision: clear underflow and a new underflow on one edge
    cfg_we = 1; cfg_sel = 3'd3; cfg_wdata = 8'b0010; bus_rx_pop = 1;
    tick();
    cfg_we = 0; cfg_sel = 3'd7; bus_rx_pop = 0;
    chk("R8 event wins over clear", raw_int[2], 1);
    cfg_write(3, 8'b0010);
    chk("R8 underflow cleared", raw_int[2], 0);
    chk("R8 rx overflow kept", raw_int[3], 1);
    bus_pop();
    cfg_write(3, 8'b0001);
    chk("R8 clear all", raw_int[3:1], 0);

    // R10 mask sweep with raw = 10101
    bus_pop();
    cfg_write(1, 0);
    chk("R10 raw setup", raw_int, 5'b10101);
    for (int m = 0; m < 32; m++) begin
      cfg_write(2, m);
      chk("R10 masked", masked_int, 5'b10101 & m);
      chk("R10 irq", irq, ((5'b10101 & m) != 0));
    end
    cfg_read(2, v);
    chk("R9 mask readback", v, 31);
    cfg_write(3, 1);

    // R11 request level sweep
    cfg_write(4, 3);
    for (lvl = 0; lvl <= DEPTH; lvl++) begin
      for (int dl = 0; dl < DEPTH; dl++) begin
        cfg_write(5, dl);
        cfg_write(6, dl);
        chk("R11 tx request", tx_dma_req, (lvl <= dl));
        chk("R11 rx request", rx_dma_req, (lvl > dl));
      end
      if (lvl < DEPTH) begin
        bus_tx_push = 1; eng_rx_push = 1; tick();
        bus_tx_push = 0; eng_rx_push = 0;
      end
    end
    cfg_write(5, 7);
    cfg_write(6, 0);
    cfg_write(4, 0);
    chk("R11 disabled both", {tx_dma_req, rx_dma_req}, 0);
    cfg_write(4, 1);
    chk("R11 rx only", {tx_dma_req, rx_dma_req}, 1);
    cfg_write(4, 2);
    chk("R11 tx only tx level above", {tx_dma_req, rx_dma_req}, 0);

    // R13 busy
    eng_busy = 1; tick();
    chk("R13 busy set", status[0], 1);
    eng_busy = 0; tick();
    chk("R13 busy clear", status[0], 0);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule